// File: doc/BRIEF.md
# Processor Mailbox Unit

This block passes 32-bit messages between a local compute core and a control processor. It holds three queues. Two carry messages from the core to the control side: a plain queue and a signalling queue. Every message written into the signalling queue raises an interrupt line. The third queue carries messages from the control side to the core. The two outbound queues hold one message each. The inbound queue holds four.

The core side works like a blocking channel. Each queue has a request/acknowledge pair. A request is held until the acknowledge appears, so the core waits for as long as the queue cannot serve it. The core also sees a count per queue: free slots for each outbound queue and waiting messages for the inbound queue.

The control side sees a small register map with single-cycle write and read strobes and a combinational read-data path. An outbound queue is drained by reading its data register. The fill levels are read from a status register. Writes to the inbound queue are never refused: when the queue is full, the newest stored message is replaced.

Top module: `mbox_hub`

## Requirements
- R1: After reset is released, every queue is empty: `core_obx_free` and `core_obi_free` equal 1, `core_ibx_avail` equals 0, `irq` is low, and the status register reads 0.
- R2: A core write to the plain outbound queue is acknowledged in the same cycle when the queue is empty. The 32-bit message is returned unchanged by a control read of address 0, and that read empties the queue.
- R3: While an outbound queue is full, a core write request to it sees its acknowledge low. The request does not change the stored message, and that queue's free count reads 0.
- R4: The signalling outbound queue behaves like the plain one, with its data at control address 1. In the cycle after each accepted core write to it, `irq` is high.
- R5: Once high, `irq` stays high until the control side reads address 1 or writes any value to address 4. If a clearing access and an accepted signalling write fall on the same cycle, `irq` stays high.
- R6: Control writes to address 2 fill the four-entry inbound queue. The core reads the messages in arrival order, with the acknowledge and data valid in the same cycle. `core_ibx_avail` counts the waiting messages.
- R7: A control write to address 2 while four messages wait, with no core read in the same cycle, replaces the newest stored message. The three older messages keep their order and the count stays 4.
- R8: A core read request while the inbound queue is empty sees its acknowledge low and changes no state.
- R9: A control read of an empty outbound queue's data address returns the last message read from that queue (0 if none was ever read) and changes no state.
- R10: The status register at address 3 holds the plain outbound fill count in bits 7:0, the signalling outbound fill count in bits 15:8 and the inbound fill count in bits 23:16. All other bits are 0. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| core_obx_req | input | 1 | Core write request, plain outbound queue |
| core_obx_data | input | 32 | Core write message, plain outbound queue |
| core_obx_ack | output | 1 | Plain outbound write accepted this cycle |
| core_obx_free | output | OB_CW | Free slots in plain outbound queue |
| core_obi_req | input | 1 | Core write request, signalling outbound queue |
| core_obi_data | input | 32 | Core write message, signalling outbound queue |
| core_obi_ack | output | 1 | Signalling outbound write accepted this cycle |
| core_obi_free | output | OB_CW | Free slots in signalling outbound queue |
| core_ibx_req | input | 1 | Core read request, inbound queue |
| core_ibx_ack | output | 1 | Inbound read served this cycle |
| core_ibx_data | output | 32 | Inbound message, valid with acknowledge |
| core_ibx_avail | output | IB_CW | Messages waiting in inbound queue |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_rd | input | 1 | Control register read strobe |
| ctl_addr | input | 3 | Control register address |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data (combinational) |
| irq | output | 1 | Interrupt to the control processor |

## Verification
A wrong pointer or count shows up at the ports within one cycle. A free or available count is off, an acknowledge appears or is missing against a full or empty queue, or the status fields disagree with the number of accepted writes minus reads. A slot corrupted by an overwrite aimed at the wrong entry stays hidden until that slot is drained. For that reason the bench sweeps the number of inbound writes from zero past the overwrite point and drains each run completely, comparing every message. A held interrupt that clears early or late is seen on `irq` the cycle after the access that should or should not have cleared it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MSG_W = 32;

  typedef enum logic [2:0] {
    REG_OBX  = 3'd0,
    REG_OBI  = 3'd1,
    REG_IBX  = 3'd2,
    REG_STAT = 3'd3,
    REG_IACK = 3'd4
  } mbox_reg_e;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW        = 32,
  parameter int DEPTH     = 4,
  parameter bit OVERWRITE = 1'b0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [DW-1:0] last,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [2**AW];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, newest;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] last_q, last_d;
  logic          do_push, do_pop, do_ovw;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign head  = mem[rd_ptr_q];
  assign last  = last_q;
  assign count = cnt_q;

  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || pop);
  assign newest  = (wr_ptr_q == '0) ? AW'(DEPTH - 1) : wr_ptr_q - 1'b1;

  generate
    if (OVERWRITE) begin : g_ovw
      assign do_ovw = push && full && !pop;
    end else begin : g_stall
      assign do_ovw = 1'b0;
    end
  endgenerate

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    last_d   = last_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      last_d   = head;
    end
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      last_q   <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)      mem[wr_ptr_q] <= push_data;
    else if (do_ovw)  mem[newest]   <= push_data;
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb irq_d = set || (irq_q && !clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
  import mbox_pkg::*;
#(
  parameter int OB_DEPTH = 1,
  parameter int IB_DEPTH = 4,
  localparam int OB_CW = $clog2(OB_DEPTH + 1),
  localparam int IB_CW = $clog2(IB_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_obx_req,
  input  logic [MSG_W-1:0] core_obx_data,
  output logic             core_obx_ack,
  output logic [OB_CW-1:0] core_obx_free,
  input  logic             core_obi_req,
  input  logic [MSG_W-1:0] core_obi_data,
  output logic             core_obi_ack,
  output logic [OB_CW-1:0] core_obi_free,
  input  logic             core_ibx_req,
  output logic             core_ibx_ack,
  output logic [MSG_W-1:0] core_ibx_data,
  output logic [IB_CW-1:0] core_ibx_avail,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic [2:0]       ctl_addr,
  input  logic [MSG_W-1:0] ctl_wdata,
  output logic [MSG_W-1:0] ctl_rdata,
  output logic             irq
);
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic [MSG_W-1:0] obx_head, obx_last, obi_head, obi_last, ibx_head, ibx_last;
  logic [OB_CW-1:0] obx_cnt, obi_cnt;
  logic [IB_CW-1:0] ibx_cnt;
  logic obx_full, obx_empty, obi_full, obi_empty, ibx_full, ibx_empty;
  logic obx_pop, obi_pop, ibx_push, iack_wr;

  assign core_obx_ack = core_obx_req && !obx_full;
  assign core_obi_ack = core_obi_req && !obi_full;
  assign core_ibx_ack = core_ibx_req && !ibx_empty;

  assign obx_pop  = ctl_rd && (ctl_addr == REG_OBX);
  assign obi_pop  = ctl_rd && (ctl_addr == REG_OBI);
  assign ibx_push = ctl_wr && (ctl_addr == REG_IBX);
  assign iack_wr  = ctl_wr && (ctl_addr == REG_IACK);

  mbox_fifo #(.DW(MSG_W), .DEPTH(OB_DEPTH), .OVERWRITE(1'b0)) u_obx (
    .clk(clk), .rst_n(srst_n), .push(core_obx_ack), .push_data(core_obx_data),
    .pop(obx_pop), .head(obx_head), .last(obx_last), .count(obx_cnt),
    .full(obx_full), .empty(obx_empty));

  mbox_fifo #(.DW(MSG_W), .DEPTH(OB_DEPTH), .OVERWRITE(1'b0)) u_obi (
    .clk(clk), .rst_n(srst_n), .push(core_obi_ack), .push_data(core_obi_data),
    .pop(obi_pop), .head(obi_head), .last(obi_last), .count(obi_cnt),
    .full(obi_full), .empty(obi_empty));

  mbox_fifo #(.DW(MSG_W), .DEPTH(IB_DEPTH), .OVERWRITE(1'b1)) u_ibx (
    .clk(clk), .rst_n(srst_n), .push(ibx_push), .push_data(ctl_wdata),
    .pop(core_ibx_ack), .head(ibx_head), .last(ibx_last), .count(ibx_cnt),
    .full(ibx_full), .empty(ibx_empty));

  mbox_irq u_irq (
    .clk(clk), .rst_n(srst_n), .set(core_obi_ack),
    .clr(obi_pop || iack_wr), .irq(irq));

  assign core_obx_free  = OB_CW'(OB_DEPTH) - obx_cnt;
  assign core_obi_free  = OB_CW'(OB_DEPTH) - obi_cnt;
  assign core_ibx_avail = ibx_cnt;
  assign core_ibx_data  = ibx_head;

  always_comb begin
    ctl_rdata = '0;
    case (ctl_addr)
      REG_OBX:  ctl_rdata = obx_empty ? obx_last : obx_head;
      REG_OBI:  ctl_rdata = obi_empty ? obi_last : obi_head;
      REG_STAT: ctl_rdata = {8'h00, 8'(ibx_cnt), 8'(obi_cnt), 8'(obx_cnt)};
      default:  ctl_rdata = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^{ibx_last, ibx_full};
endmodule

// File: rtl/mbox_hub_chk.sv
module mbox_hub_chk
  import mbox_pkg::*;
#(
  parameter int OB_DEPTH = 1,
  parameter int IB_DEPTH = 4,
  localparam int OB_CW = $clog2(OB_DEPTH + 1),
  localparam int IB_CW = $clog2(IB_DEPTH + 1)
) (
  input logic             clk,
  input logic             srst_n,
  input logic             core_obx_req,
  input logic             core_obx_ack,
  input logic [OB_CW-1:0] core_obx_free,
  input logic             core_obi_req,
  input logic             core_obi_ack,
  input logic [OB_CW-1:0] core_obi_free,
  input logic             core_ibx_req,
  input logic             core_ibx_ack,
  input logic [IB_CW-1:0] core_ibx_avail,
  input logic             ctl_wr,
  input logic             ctl_rd,
  input logic [2:0]       ctl_addr,
  input logic             irq
);
  // R3
  obx_stall_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (core_obx_req && core_obx_free == '0) |-> !core_obx_ack);

  // R3
  obi_stall_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (core_obi_req && core_obi_free == '0) |-> !core_obi_ack);

  // R4
  irq_set_chk: assert property (@(posedge clk) disable iff (!srst_n)
    core_obi_ack |=> irq);

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (irq && !(ctl_rd && ctl_addr == REG_OBI) && !(ctl_wr && ctl_addr == REG_IACK)) |=> irq);

  // R6
  ibx_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    core_ibx_avail <= IB_CW'(IB_DEPTH));

  // R7
  ibx_overwrite_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ctl_wr && ctl_addr == REG_IBX && core_ibx_avail == IB_CW'(IB_DEPTH) && !core_ibx_ack)
    |=> core_ibx_avail == IB_CW'(IB_DEPTH));

  // R8
  ibx_empty_stall_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (core_ibx_req && core_ibx_avail == '0) |-> !core_ibx_ack);

  // R9
  obx_empty_read_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ctl_rd && ctl_addr == REG_OBX && core_obx_free == OB_CW'(OB_DEPTH) && !core_obx_ack)
    |=> core_obx_free == OB_CW'(OB_DEPTH));
endmodule

bind mbox_hub mbox_hub_chk #(.OB_DEPTH(OB_DEPTH), .IB_DEPTH(IB_DEPTH)) u_chk (.*);

// File: tb/mbox_hub_test.sv
module mbox_hub_test;
  localparam int PERIOD = 10;
  localparam int IBD = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_obx_req, core_obi_req, core_ibx_req;
  logic [31:0] core_obx_data, core_obi_data;
  logic        core_obx_ack, core_obi_ack, core_ibx_ack;
  logic [0:0]  core_obx_free, core_obi_free;
  logic [31:0] core_ibx_data;
  logic [2:0]  core_ibx_avail;
  logic        ctl_wr, ctl_rd;
  logic [2:0]  ctl_addr;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  mbox_hub uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl_read(input logic [2:0] a, output logic [31:0] d);
    ctl_rd = 1'b1; ctl_addr = a;
    #1 d = ctl_rdata;
    step();
    ctl_rd = 1'b0;
  endtask

  task automatic ctl_write(input logic [2:0] a, input logic [31:0] d);
    ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic obx_put(input logic [31:0] d, output logic ack);
    core_obx_req = 1'b1; core_obx_data = d;
    #1 ack = core_obx_ack;
    step();
    core_obx_req = 1'b0;
  endtask

  task automatic obi_put(input logic [31:0] d, output logic ack);
    core_obi_req = 1'b1; core_obi_data = d;
    #1 ack = core_obi_ack;
    step();
    core_obi_req = 1'b0;
  endtask

  task automatic ibx_get(output logic ack, output logic [31:0] d);
    core_ibx_req = 1'b1;
    #1 begin ack = core_ibx_ack; d = core_ibx_data; end
    step();
    core_ibx_req = 1'b0;
  endtask

  function automatic logic [31:0] ib_exp(input int n, input int k);
    logic [31:0] base;
    base = {8'(n), 24'h5A_0000};
    if (n <= IBD || k < IBD - 1) return base + 32'(k);
    return base + 32'(n - 1);
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic        a;
    logic [31:0] d;
    logic [31:0] last_obx;
    core_obx_req = 0; core_obi_req = 0; core_ibx_req = 0;
    core_obx_data = 0; core_obi_data = 0;
    ctl_wr = 0; ctl_rd = 0; ctl_addr = 0; ctl_wdata = 0;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 obx_free", 32'(core_obx_free), 32'd1);
    chk("R1 obi_free", 32'(core_obi_free), 32'd1);
    chk("R1 ibx_avail", 32'(core_ibx_avail), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    ctl_read(3'd3, d);
    chk("R1 status", d, 32'd0);
    // R9 empty read before any message
    ctl_read(3'd0, d);
    chk("R9 never-read obx", d, 32'd0);

    // R2 R3 R9 plain outbound sweep
    last_obx = 32'd0;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = (32'h1 << (i * 4)) ^ 32'hF0E1_D2C3 + 32'(i * 7);
      obx_put(v, a);
      chk("R2 ack when empty", 32'(a), 32'd1);
      chk("R3 free zero", 32'(core_obx_free), 32'd0);
      ctl_read(3'd3, d);
      chk("R10 status obx", d, 32'h0000_0001);
      obx_put(~v, a);
      chk("R3 ack low when full", 32'(a), 32'd0);
      ctl_read(3'd0, d);
      chk("R2 R3 data unchanged", d, v);
      chk("R2 emptied", 32'(core_obx_free), 32'd1);
      ctl_read(3'd0, d);
      chk("R9 last value", d, v);
      chk("R9 still empty", 32'(core_obx_free), 32'd1);
      last_obx = v;
    end
    ctl_read(3'd6, d);
    chk("R10 unmapped", d, 32'd0);

    // R4 R5 signalling queue, clear by read
    obi_put(32'hCAFE_0001, a);
    chk("R4 ack", 32'(a), 32'd1);
    chk("R4 irq set", 32'(irq), 32'd1);
    chk("R3 obi free zero", 32'(core_obi_free), 32'd0);
    obi_put(32'h0BAD_0BAD, a);
    chk("R3 obi ack low", 32'(a), 32'd0);
    repeat (5) step();
    chk("R5 irq held", 32'(irq), 32'd1);
    ctl_read(3'd3, d);
    chk("R10 status obi", d, 32'h0000_0100);
    ctl_read(3'd1, d);
    chk("R4 obi data", d, 32'hCAFE_0001);
    chk("R5 irq cleared by read", 32'(irq), 32'd0);
    ctl_read(3'd1, d);
    chk("R9 obi last", d, 32'hCAFE_0001);

    // R5 clear by acknowledge write, queue content kept
    obi_put(32'hCAFE_0002, a);
    chk("R4 irq set again", 32'(irq), 32'd1);
    ctl_write(3'd4, 32'h0);
    chk("R5 irq cleared by ack", 32'(irq), 32'd0);
    chk("R5 queue kept", 32'(core_obi_free), 32'd0);
    ctl_read(3'd1, d);
    chk("R4 obi data 2", d, 32'hCAFE_0002);

    // R5 set wins over same-cycle acknowledge
    core_obi_req = 1'b1; core_obi_data = 32'hCAFE_0003;
    ctl_wr = 1'b1; ctl_addr = 3'd4; ctl_wdata = 32'h0;
    step();
    core_obi_req = 1'b0; ctl_wr = 1'b0;
    chk("R5 set wins", 32'(irq), 32'd1);
    ctl_read(3'd1, d);
    chk("R4 obi data 3", d, 32'hCAFE_0003);
    chk("R5 cleared", 32'(irq), 32'd0);

    // R8 empty inbound read
    ibx_get(a, d);
    chk("R8 ack low", 32'(a), 32'd0);
    chk("R8 avail zero", 32'(core_ibx_avail), 32'd0);

    // R6 R7 inbound sweep over write counts
    for (int n = 0; n < 8; n++) begin
      int stored;
      stored = (n < IBD) ? n : IBD;
      for (int k = 0; k < n; k++) ctl_write(3'd2, {8'(n), 24'h5A_0000} + 32'(k));
      chk("R6 R7 avail", 32'(core_ibx_avail), 32'(stored));
      ctl_read(3'd3, d);
      chk("R10 status ibx", d, {8'h00, 8'(stored), 16'h0000});
      for (int k = 0; k < stored; k++) begin
        ibx_get(a, d);
        chk("R6 ack", 32'(a), 32'd1);
        chk(n > IBD ? "R7 order" : "R6 order", d, ib_exp(n, k));
      end
      ibx_get(a, d);
      chk("R8 drained stall", 32'(a), 32'd0);
      chk("R8 avail kept", 32'(core_ibx_avail), 32'd0);
    end

    // R6 simultaneous write and read with a full queue
    for (int k = 0; k < IBD; k++) ctl_write(3'd2, 32'h7700_0000 + 32'(k));
    core_ibx_req = 1'b1; ctl_wr = 1'b1; ctl_addr = 3'd2; ctl_wdata = 32'h7700_0099;
    #1 chk("R6 head while full", core_ibx_data, 32'h7700_0000);
    step();
    core_ibx_req = 1'b0; ctl_wr = 1'b0;
    chk("R6 count kept", 32'(core_ibx_avail), 32'd4);
    for (int k = 1; k < IBD; k++) begin
      ibx_get(a, d);
      chk("R6 order after concurrent", d, 32'h7700_0000 + 32'(k));
    end
    ibx_get(a, d);
    chk("R6 pushed during full read", d, 32'h7700_0099);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule